// File: doc/BRIEF.md
# Serial Port Register and FIFO Controller

This block is the bus-facing half of a serial port. Software reaches it through four word registers on a simple single-cycle port: a control word, a receive-data window, a transmit-data window and a status word. Behind the windows sit two byte FIFOs, one per direction, of parameterised depth (16 by default). The block hands queued transmit bytes to an external shift engine and stores bytes that an external receive engine delivers.

The control word drives the frame format (data length, stop bits, parity mode), flow control and loopback settings to the engines. It also holds the per-direction interrupt enables and two DMA enable bits that are only stored. The status word reports sticky pending and error flags, which are cleared by writing one to them. It also shows the FIFO empty and full states, the modem lines, engine busy, and one occupancy field that a control bit points at either FIFO. The interrupt output is a level-high OR of the enabled pending flags. Clearing the enable bit flushes both FIFOs and keeps the engines idle.

Register select uses address bits 3:2 with bits 1:0 zero: 0x0 control, 0x4 receive data, 0x8 transmit data, 0xC status.

Top module: `serial_port_regs`

## Requirements
- R1: After reset the control word reads 0x0000_0000, the status word reads 0x0000_0520 (RX empty bit 5, RTS bit 8 and TX empty bit 10 set), and irq is low.
- R2: Control keeps only bits 1:0 (length), 2 (two stop), 6:4 (parity), 12 (flow control), 14 (level select), 15 (enable), 16/17 (DMA), 18 (RX irq enable), 19 (TX irq enable) and 20 (loopback). Writing all ones reads back 0x001F_D077. cfg_len, cfg_two_stop, cfg_parity, cfg_flow, cfg_loopback and eng_enable mirror these fields.
- R3: While enabled, each write to the transmit window queues bits 7:0. tx_valid is high while the queue holds data, tx_data shows the oldest byte, and tx_take removes it, so bytes leave in write order.
- R4: With FIFO_DEPTH bytes queued, status bit 6 (TX full) is set. A further transmit write is dropped and sets status bit 3 (TX error).
- R5: Reading the receive window returns the oldest received byte in bits 7:0 and removes it. A read while the RX FIFO is empty returns zero and changes nothing.
- R6: A byte that arrives on rx_valid while the RX FIFO is full is dropped and sets status bit 2 (overrun).
- R7: A byte that arrives with rx_err high sets status bit 4 and is still stored.
- R8: Writing 1 to status bits 0 to 4 clears them, and writing 0 leaves them alone. A flag whose set condition holds in the same cycle stays set.
- R9: Status bits 16:11 give the TX FIFO occupancy when control bit 14 is 1 and the RX occupancy when it is 0.
- R10: Status bit 0 sets one cycle after the enabled RX FIFO is non-empty. Status bit 1 sets while the block is enabled and the TX FIFO is not full. Both stay set until cleared.
- R11: irq = (status bit 0 AND control bit 18) OR (status bit 1 AND control bit 19).
- R12: With control bit 15 clear, both FIFOs are emptied, tx_valid is low, and bytes from rx_valid and transmit writes are ignored.
- R13: Status bit 7 shows cts_in and bit 17 shows tx_busy. Status bit 8 shows rts_out, which is "RX FIFO not full" when control bit 12 is set and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_take | input | 1 | Engine consumes tx_data |
| tx_busy | input | 1 | Engine is shifting |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data is valid this cycle |
| rx_err | input | 1 | Received byte had a framing or parity fault |
| cts_in | input | 1 | Clear-to-send line state |
| rts_out | output | 1 | Request-to-send line drive |
| eng_enable | output | 1 | Engines may run |
| cfg_len | output | 2 | Data length code (0 = 5 bits to 3 = 8 bits) |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_parity | output | 3 | Parity mode code |
| cfg_flow | output | 1 | Hardware flow control enable |
| cfg_loopback | output | 1 | Internal loopback |
| irq | output | 1 | Level-high interrupt |

## Verification
Register reads are combinational, so a read returns data in the same cycle it is issued. The access edge updates the control word, the FIFO counts and the error flags, so each one is visible from the next cycle. The pending flags follow the FIFO state one edge later, and irq follows the flags without delay. The bench drives on the falling edge, samples 1 ns after it, and waits at least two cycles after any stimulus before it reads status. Transmit bytes are checked by a monitor against a queue that the push task fills. Receive reads are compared against a queue that the receive driver fills, and dropped bytes are never queued.

// File: rtl/serial_port_pkg.sv
`timescale 1ns/1ps
package serial_port_pkg;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_RXD  = 2'd1,
        REG_TXD  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    // control word fields
    localparam int unsigned CTL_LEN_LO  = 0;
    localparam int unsigned CTL_STOP2   = 2;
    localparam int unsigned CTL_PAR_LO  = 4;
    localparam int unsigned CTL_FLOW    = 12;
    localparam int unsigned CTL_LVLSEL  = 14;
    localparam int unsigned CTL_EN      = 15;
    localparam int unsigned CTL_RXIE    = 18;
    localparam int unsigned CTL_TXIE    = 19;
    localparam int unsigned CTL_LOOP    = 20;
    localparam logic [31:0] CTL_MASK    = 32'h001F_D077;

    // status word fields
    localparam int unsigned NUM_FLAGS   = 5;
    localparam int unsigned FL_RXPEND   = 0;
    localparam int unsigned FL_TXPEND   = 1;
    localparam int unsigned FL_OVR      = 2;
    localparam int unsigned FL_TXERR    = 3;
    localparam int unsigned FL_RXST     = 4;
    localparam int unsigned ST_RXEMPTY  = 5;
    localparam int unsigned ST_TXFULL   = 6;
    localparam int unsigned ST_CTS      = 7;
    localparam int unsigned ST_RTS      = 8;
    localparam int unsigned ST_TXEMPTY  = 10;
    localparam int unsigned ST_LVL_LO   = 11;
    localparam int unsigned LVL_W       = 6;
    localparam int unsigned ST_BUSY     = 17;

endpackage

// File: rtl/sp_fifo.sv
`timescale 1ns/1ps
module sp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CNT_W'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign rdata   = mem[s_q.rd];
    assign count   = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wr = step(s_q.wr);
            if (pop_ok)  s_d.rd = step(s_q.rd);
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[s_q.wr] <= wdata;
    end
endmodule

// File: rtl/sp_sticky_flags.sv
`timescale 1ns/1ps
module sp_sticky_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    // a set in the same cycle wins over a clear
    always_comb begin
        flags_d = set | (flags_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/serial_port_regs.sv
`timescale 1ns/1ps
module serial_port_regs
    import serial_port_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic              tx_busy,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic              cts_in,
    output logic              rts_out,
    output logic              eng_enable,
    output logic [1:0]        cfg_len,
    output logic              cfg_two_stop,
    output logic [2:0]        cfg_parity,
    output logic              cfg_flow,
    output logic              cfg_loopback,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [31:0] ctl;
    } regs_t;

    regs_t r_d, r_q;
    logic [31:0] ctl_q;

    logic hit, wr_ctl, wr_txd, wr_stat, rd_rxd, en;
    reg_sel_e sel;

    logic [7:0]       rx_head;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic [NUM_FLAGS-1:0] fl_set, fl_clr, flags;
    logic [LVL_W-1:0] level;
    logic [31:0]      status;

    assign ctl_q = r_q.ctl;
    assign en    = ctl_q[CTL_EN];

    // address decode
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign hit     = bus_sel && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
    assign wr_ctl  = hit && bus_wr  && (sel == REG_CTL);
    assign wr_txd  = hit && bus_wr  && (sel == REG_TXD);
    assign wr_stat = hit && bus_wr  && (sel == REG_STAT);
    assign rd_rxd  = hit && !bus_wr && (sel == REG_RXD);

    always_comb begin
        r_d = r_q;
        if (wr_ctl) r_d.ctl = bus_wdata & CTL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    sp_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!en),
        .push  (wr_txd && en),
        .wdata (bus_wdata[7:0]),
        .pop   (tx_take && en),
        .rdata (tx_data),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    sp_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!en),
        .push  (rx_valid && en),
        .wdata (rx_data),
        .pop   (rd_rxd && en),
        .rdata (rx_head),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    always_comb begin
        fl_set            = '0;
        fl_set[FL_RXPEND] = en && !rx_empty;
        fl_set[FL_TXPEND] = en && !tx_full;
        fl_set[FL_OVR]    = en && rx_valid && rx_full;
        fl_set[FL_TXERR]  = en && wr_txd && tx_full;
        fl_set[FL_RXST]   = en && rx_valid && rx_err;
        fl_clr            = wr_stat ? bus_wdata[NUM_FLAGS-1:0] : '0;
    end

    sp_sticky_flags #(.N(NUM_FLAGS)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (fl_clr),
        .flags (flags)
    );

    assign rts_out = ctl_q[CTL_FLOW] ? !rx_full : 1'b1;
    assign level   = ctl_q[CTL_LVLSEL] ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);

    always_comb begin
        status                              = '0;
        status[NUM_FLAGS-1:0]               = flags;
        status[ST_RXEMPTY]                  = rx_empty;
        status[ST_TXFULL]                   = tx_full;
        status[ST_CTS]                      = cts_in;
        status[ST_RTS]                      = rts_out;
        status[ST_TXEMPTY]                  = tx_empty;
        status[ST_LVL_LO +: LVL_W]          = level;
        status[ST_BUSY]                     = tx_busy;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit && !bus_wr) begin
            case (sel)
                REG_CTL:  bus_rdata = ctl_q;
                REG_RXD:  bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
                REG_STAT: bus_rdata = status;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign tx_valid     = en && !tx_empty;
    assign eng_enable   = en;
    assign cfg_len      = ctl_q[CTL_LEN_LO +: 2];
    assign cfg_two_stop = ctl_q[CTL_STOP2];
    assign cfg_parity   = ctl_q[CTL_PAR_LO +: 3];
    assign cfg_flow     = ctl_q[CTL_FLOW];
    assign cfg_loopback = ctl_q[CTL_LOOP];
    assign irq          = (flags[FL_RXPEND] && ctl_q[CTL_RXIE]) ||
                          (flags[FL_TXPEND] && ctl_q[CTL_TXIE]);
endmodule

// File: rtl/sp_regs_chk.sv
`timescale 1ns/1ps
module sp_regs_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic [31:0]                ctl,
    input logic [4:0]                 flags,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       tx_full,
    input logic                       rx_full,
    input logic                       rx_empty,
    input logic                       wr_txd,
    input logic                       rd_rxd,
    input logic                       tx_take,
    input logic                       rx_valid,
    input logic                       irq,
    input logic [31:0]                bus_rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH))); // R4

    AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_txd && tx_full && !tx_take) |=> (tx_cnt == CNT_W'(DEPTH)) && flags[3]); // R4

    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_valid && rx_full) |=> flags[2]); // R6

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty) |-> (bus_rdata == 32'h0)); // R5

    AST_RX_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rx_empty) |=> flags[0]); // R10

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl[18] || ctl[19])); // R11

    AST_FLUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tx_cnt == '0) && (rx_cnt == '0)); // R12
endmodule

bind serial_port_regs sp_regs_chk #(.DEPTH(FIFO_DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ctl       (ctl_q),
    .flags     (flags),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .tx_full   (tx_full),
    .rx_full   (rx_full),
    .rx_empty  (rx_empty),
    .wr_txd    (wr_txd),
    .rd_rxd    (rd_rxd),
    .tx_take   (tx_take),
    .rx_valid  (rx_valid),
    .irq       (irq),
    .bus_rdata (bus_rdata)
);

// File: tb/test_serial_port_regs.sv
`timescale 1ns/1ps
module test_serial_port_regs;
    localparam int DEPTH = 16;
    localparam logic [3:0] A_CTL = 4'h0, A_RXD = 4'h4, A_TXD = 4'h8, A_STAT = 4'hC;
    localparam logic [31:0] EN = 32'h0000_8000;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [3:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [7:0] tx_data, rx_data = 0;
    logic tx_valid, tx_take = 0, tx_busy = 0, rx_valid = 0, rx_err = 0, cts_in = 0;
    logic rts_out, eng_enable, cfg_two_stop, cfg_flow, cfg_loopback, irq;
    logic [1:0] cfg_len;
    logic [2:0] cfg_parity;

    int checks = 0, errors = 0;
    bit done = 0, mon_take = 0;
    logic [7:0] txq[$], rxq[$];
    logic [31:0] v;

    always #2 clk = ~clk;

    serial_port_regs #(.FIFO_DEPTH(DEPTH), .ADDR_W(4)) i_serial_port_regs (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: queue a transmit byte and record it as expected output
    task automatic tx_push(input logic [7:0] b);
        bus_write(A_TXD, {24'h0, b});
        txq.push_back(b);
    endtask

    task automatic rx_send(input logic [7:0] b, input logic err, input bit kept);
        @(negedge clk); rx_valid = 1; rx_data = b; rx_err = err;
        @(negedge clk); rx_valid = 0; rx_err = 0;
        if (kept) rxq.push_back(b);
    endtask

    task automatic read_rx();
        logic [31:0] d;
        logic [7:0] e;
        bus_read(A_RXD, d);
        e = rxq.pop_front();
        chk("R5 rx data", d, {24'h0, e});
    endtask

    task automatic drain_tx();
        mon_take = 1;
        for (int i = 0; i < 200 && txq.size() != 0; i++) @(negedge clk);
        idle(2);
        mon_take = 0;
        chk("R3 tx queue drained", 32'(txq.size()), 0);
        chk("R3 tx_valid low after drain", 32'(tx_valid), 0);
    endtask

    // monitor: compare each byte the engine takes with the scoreboard
    always @(negedge clk) begin
        #1;
        if (mon_take && tx_valid) begin
            if (txq.size() == 0) chk("R3 unexpected tx byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
            else chk("R3 tx order", {24'h0, tx_data}, {24'h0, txq.pop_front()});
            tx_take = 1;
        end else begin
            tx_take = 0;
        end
    end

    initial begin
        #600000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        idle(2);
        // R1 reset state
        bus_read(A_CTL, v);  chk("R1 ctl reset", v, 32'h0);
        bus_read(A_STAT, v); chk("R1 status reset", v, 32'h0000_0520);
        chk("R1 irq reset", 32'(irq), 0);

        // R2 writable mask and config outputs
        bus_write(A_CTL, 32'hFFFF_FFFF);
        bus_read(A_CTL, v); chk("R2 ctl mask", v, 32'h001F_D077);
        chk("R2 cfg fields", {24'h0, cfg_len, cfg_two_stop, cfg_parity, cfg_flow, cfg_loopback},
            {24'h0, 2'b11, 1'b1, 3'b111, 1'b1, 1'b1});
        bus_write(A_CTL, 32'h0000_0016);
        chk("R2 cfg partial", {26'h0, cfg_len, cfg_two_stop, cfg_parity},
            {26'h0, 2'b10, 1'b1, 3'b001});
        chk("R2 eng_enable off", 32'(eng_enable), 0);

        // R10/R11 tx pending
        bus_write(A_CTL, EN); idle(2);
        bus_read(A_STAT, v); chk("R10 tx pending", 32'(v[1]), 1);
        chk("R11 irq off without enables", 32'(irq), 0);
        bus_write(A_CTL, EN | 32'h0008_0000);
        chk("R11 irq from tx pending", 32'(irq), 1);

        // R3/R9 transmit path
        bus_write(A_CTL, EN | 32'h0000_4000);
        tx_push(8'h11); tx_push(8'h22); tx_push(8'h33);
        bus_read(A_STAT, v); chk("R9 tx level", 32'(v[16:11]), 3);
        chk("R3 tx_valid", 32'(tx_valid), 1);
        drain_tx();

        // R4 full and drop
        for (int i = 0; i < DEPTH; i++) tx_push(8'(8'h40 + i));
        bus_read(A_STAT, v);
        chk("R4 tx full", 32'(v[6]), 1);
        chk("R4 no tx error yet", 32'(v[3]), 0);
        chk("R9 tx level full", 32'(v[16:11]), DEPTH);
        bus_write(A_TXD, 32'h0000_00EE);
        bus_read(A_STAT, v); chk("R4 tx error on drop", 32'(v[3]), 1);
        bus_write(A_STAT, 32'h0000_0008);
        bus_read(A_STAT, v); chk("R8 tx error cleared", 32'(v[3]), 0);
        drain_tx();

        // R5/R9/R10/R11 receive path
        bus_write(A_CTL, EN | 32'h0004_0000);
        rx_send(8'hA5, 0, 1); rx_send(8'h3C, 0, 1); idle(2);
        bus_read(A_STAT, v);
        chk("R10 rx pending", 32'(v[0]), 1);
        chk("R9 rx level", 32'(v[16:11]), 2);
        chk("R11 irq from rx pending", 32'(irq), 1);
        read_rx(); read_rx();
        bus_read(A_RXD, v); chk("R5 empty read", v, 32'h0);
        bus_read(A_STAT, v); chk("R5 still empty", 32'(v[5]), 1);
        chk("R10 rx pending sticky", 32'(v[0]), 1);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); chk("R8 zero write keeps flag", 32'(v[0]), 1);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, v); chk("R8 rx pending cleared", 32'(v[0]), 0);
        chk("R11 irq dropped", 32'(irq), 0);

        // R6/R13 overrun and rts
        for (int i = 0; i < DEPTH; i++) rx_send(8'(8'h80 + i), 0, 1);
        rx_send(8'hFF, 0, 0); idle(1);
        bus_read(A_STAT, v);
        chk("R6 overrun", 32'(v[2]), 1);
        chk("R9 rx level full", 32'(v[16:11]), DEPTH);
        chk("R13 rts without flow", 32'(v[8]), 1);
        bus_write(A_CTL, EN | 32'h0004_1000);
        bus_read(A_STAT, v); chk("R13 rts when full", 32'(v[8]), 0);
        chk("R13 rts_out pin", 32'(rts_out), 0);
        for (int i = 0; i < DEPTH; i++) read_rx();
        bus_read(A_STAT, v); chk("R13 rts after drain", 32'(v[8]), 1);
        bus_write(A_STAT, 32'h4);
        bus_read(A_STAT, v); chk("R8 overrun cleared", 32'(v[2]), 0);

        // R7 status error
        rx_send(8'h77, 1, 1); idle(1);
        bus_read(A_STAT, v); chk("R7 rx status error", 32'(v[4]), 1);
        read_rx();
        idle(2);
        bus_write(A_STAT, 32'h1F);
        bus_read(A_STAT, v); chk("R8 clear all, tx pending holds", 32'(v[4:0]), 32'h2);

        // R13 cts and busy
        cts_in = 1; tx_busy = 1;
        bus_read(A_STAT, v);
        chk("R13 cts", 32'(v[7]), 1);
        chk("R13 busy", 32'(v[17]), 1);
        cts_in = 0; tx_busy = 0;

        // R12 disable flushes and ignores
        bus_write(A_TXD, 32'h55); bus_write(A_TXD, 32'h66);
        rx_send(8'h12, 0, 0);
        bus_write(A_CTL, 32'h0); idle(2);
        chk("R12 tx_valid off", 32'(tx_valid), 0);
        bus_read(A_STAT, v);
        chk("R12 both empty", {30'h0, v[10], v[5]}, 32'h3);
        chk("R12 rx level zero", 32'(v[16:11]), 0);
        rx_send(8'h34, 0, 0);
        bus_write(A_TXD, 32'h99);
        bus_write(A_CTL, EN | 32'h0000_4000); idle(2);
        bus_read(A_STAT, v);
        chk("R12 ignored while off", {30'h0, v[10], v[5]}, 32'h3);
        chk("R12 tx level zero", 32'(v[16:11]), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule